// File: doc/BRIEF.md
# Receive Preamble and Delimiter Stripper

This block sits at the front of an Ethernet receive path. It takes a byte stream that has already been assembled from the media-independent interface, together with a data-valid strobe and a receive-error strobe. It looks for the start-frame delimiter behind a preamble of any length. A frame is only accepted when its first byte that differs from 0x55 is exactly 0xD5. From an accepted frame it forwards only the bytes that follow the delimiter, marked with start-of-frame and end-of-frame strobes.

An attempt is rejected in two cases. The first is a wrong delimiter. The second is data-valid falling before any delimiter arrives. Either case raises a one-cycle discard flag and advances a wrapping discard counter. After a wrong delimiter, the rest of the attempt is ignored until data-valid falls.

The block holds back one byte so that the end-of-frame strobe can go with the last payload byte. It is ready for a new preamble on the cycle right after data-valid falls. Frames separated by far less than the standard inter-frame gap are therefore received intact.

Top module: `rx_sfd_strip`

## Requirements
- R1: While reset is active, and after it is released, outValid, outSof, outEof, outErr and discardFlag are low and discardCount is zero.
- R2: Any number of leading 0x55 bytes is accepted as preamble, including none and more than seven.
- R3: When the first byte of an attempt that is not 0x55 equals 0xD5, every later byte of the attempt is forwarded in order on outData. No preamble byte and no delimiter byte is ever forwarded.
- R4: When the first byte that is not 0x55 is any value other than 0xD5, nothing from that attempt is forwarded. This holds even if 0x55 or 0xD5 bytes follow it. discardFlag pulses for one cycle and discardCount increments by one.
- R5: When rxValid falls before any byte other than 0x55 has been seen, nothing is forwarded, discardFlag pulses once and discardCount increments by one.
- R6: outSof is high with the first forwarded byte and outEof is high with the last. A one-byte payload carries both. Neither strobe is ever high without outValid. The last byte leaves on the cycle after rxValid is first sampled low.
- R7: When rxValid falls right after 0xD5, nothing is forwarded and no discard is counted.
- R8: If rxErr is high in any valid cycle of an accepted attempt, outErr is high together with that frame's outEof. This includes cycles during the preamble or on the delimiter byte. outErr is never high at other times, and rxErr does not change the delimiter decision.
- R9: One idle cycle between two frames is enough for both frames to be forwarded completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxValid | input | 1 | Byte-stream data valid |
| rxData | input | 8 | Received byte |
| rxErr | input | 1 | Receive error indication |
| outValid | output | 1 | Forwarded byte valid |
| outData | output | 8 | Forwarded byte |
| outSof | output | 1 | First byte after the delimiter |
| outEof | output | 1 | Last byte of the frame |
| outErr | output | 1 | Frame saw a receive error (with outEof) |
| discardFlag | output | 1 | One-cycle pulse per rejected attempt |
| discardCount | output | CNT_W | Wrapping count of rejected attempts |

## Verification
Several rules are checked by assertions on every cycle. The frame strobes must never appear without outValid, and outErr is only allowed together with outEof. Every discard pulse must match exactly one step of the counter, and no byte may leave in the cycle of a discard pulse. The bench scenarios are the only evidence for the rest. These cover which bytes are stripped or forwarded, the delimiter decision after preambles of different lengths, and the silence after a bad delimiter even when 0xD5 follows it. They also cover the one-cycle hold-back timing of the last byte and the receipt of two frames split by a single idle cycle.

// File: rtl/rx_sfd_pkg.sv
package rx_sfd_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] PRE_BYTE = 8'h55;
  localparam logic [BYTE_W-1:0] SFD_BYTE = 8'hD5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_PASS = 2'd2,
    ST_DROP = 2'd3
  } huntState_t;

  typedef struct packed {
    logic startAttempt;
    logic capture;
    logic flush;
  } stripCtrl_t;
endpackage

// File: rtl/rx_sfd_ctrl.sv
module rx_sfd_ctrl
  import rx_sfd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output stripCtrl_t        ctrl,
  output logic              discardFlag,
  output logic [CNT_W-1:0]  discardCount
);
  huntState_t state, stateNext;
  logic discardNow;
  logic isPre, isSfd;

  assign isPre = (rxData == PRE_BYTE);
  assign isSfd = (rxData == SFD_BYTE);

  always_comb begin
    stateNext  = state;
    discardNow = 1'b0;
    ctrl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (rxValid) begin
          ctrl.startAttempt = 1'b1;
          if (isPre)      stateNext = ST_SEEK;
          else if (isSfd) stateNext = ST_PASS;
          else begin
            stateNext  = ST_DROP;
            discardNow = 1'b1;
          end
        end
      end
      ST_SEEK: begin
        if (!rxValid) begin
          stateNext  = ST_IDLE;
          discardNow = 1'b1;
        end else if (isSfd) begin
          stateNext = ST_PASS;
        end else if (!isPre) begin
          stateNext  = ST_DROP;
          discardNow = 1'b1;
        end
      end
      ST_PASS: begin
        if (rxValid) ctrl.capture = 1'b1;
        else begin
          ctrl.flush = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      ST_DROP: begin
        if (!rxValid) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      discardFlag  <= 1'b0;
      discardCount <= '0;
    end else begin
      state       <= stateNext;
      discardFlag <= discardNow;
      if (discardNow) discardCount <= discardCount + 1'b1;
    end
  end

  // R4 R5
  discard_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    discardFlag |-> discardCount == $past(discardCount) + 1'b1);

  // R4 R5
  discard_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !discardFlag |-> $stable(discardCount));
endmodule

// File: rtl/rx_sfd_dpath.sv
module rx_sfd_dpath
  import rx_sfd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxErr,
  input  stripCtrl_t        ctrl,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outSof,
  output logic              outEof,
  output logic              outErr
);
  logic [BYTE_W-1:0] holdData;
  logic holdValid;
  logic firstPending;
  logic errAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData     <= '0;
      holdValid    <= 1'b0;
      firstPending <= 1'b1;
      errAcc       <= 1'b0;
      outValid     <= 1'b0;
      outData      <= '0;
      outSof       <= 1'b0;
      outEof       <= 1'b0;
      outErr       <= 1'b0;
    end else begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outEof   <= 1'b0;
      outErr   <= 1'b0;

      if (ctrl.startAttempt) begin
        errAcc       <= rxErr;
        firstPending <= 1'b1;
      end else if (rxValid && rxErr) begin
        errAcc <= 1'b1;
      end

      if (ctrl.capture) begin
        if (holdValid) begin
          outValid     <= 1'b1;
          outData      <= holdData;
          outSof       <= firstPending;
          firstPending <= 1'b0;
        end
        holdData  <= rxData;
        holdValid <= 1'b1;
      end else if (ctrl.flush) begin
        if (holdValid) begin
          outValid <= 1'b1;
          outData  <= holdData;
          outSof   <= firstPending;
          outEof   <= 1'b1;
          outErr   <= errAcc;
        end
        holdValid    <= 1'b0;
        firstPending <= 1'b1;
      end
    end
  end

  // R6
  strobe_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outSof || outEof) |-> outValid);

  // R8
  err_on_eof_chk: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> outEof);

  // R6
  ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.capture && ctrl.flush));
endmodule

// File: rtl/rx_sfd_strip.sv
module rx_sfd_strip
  import rx_sfd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic             rxErr,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             outSof,
  output logic             outEof,
  output logic             outErr,
  output logic             discardFlag,
  output logic [CNT_W-1:0] discardCount
);
  stripCtrl_t ctrl;

  rx_sfd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rxValid      (rxValid),
    .rxData       (rxData),
    .ctrl         (ctrl),
    .discardFlag  (discardFlag),
    .discardCount (discardCount)
  );

  rx_sfd_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .rxValid  (rxValid),
    .rxData   (rxData),
    .rxErr    (rxErr),
    .ctrl     (ctrl),
    .outValid (outValid),
    .outData  (outData),
    .outSof   (outSof),
    .outEof   (outEof),
    .outErr   (outErr)
  );

  // R4
  no_out_on_discard_chk: assert property (@(posedge clk) disable iff (!rstN)
    discardFlag |-> !outValid);
endmodule

// File: tb/sim_rx_sfd_strip.sv
module sim_rx_sfd_strip;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic rxErr = 1'b0;
  logic outValid, outSof, outEof, outErr, discardFlag;
  logic [7:0] outData;
  logic [15:0] discardCount;

  int checks = 0;
  int errors = 0;

  logic [7:0] capData [64];
  logic [63:0] capSof, capEof, capErr;
  int capN = 0;
  int discSeen = 0;

  always #10 clk = ~clk;

  rx_sfd_strip u0 (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxErr(rxErr),
    .outValid(outValid), .outData(outData), .outSof(outSof), .outEof(outEof),
    .outErr(outErr), .discardFlag(discardFlag), .discardCount(discardCount)
  );

  always @(negedge clk) begin
    if (rstN && outValid && capN < 64) begin
      capData[capN] = outData;
      capSof[capN]  = outSof;
      capEof[capN]  = outEof;
      capErr[capN]  = outErr;
      capN = capN + 1;
    end
    if (rstN && discardFlag) discSeen = discSeen + 1;
  end

  // fields: [39:32] preamble length, [31:24] delimiter, [23:16] payload length,
  // [15:8] first payload byte, [7] error flag, [6:0] idle gap
  localparam logic [39:0] VECS [6] = '{
    {8'd7,  8'hD5, 8'd5, 8'h10, 1'b0, 7'd3},
    {8'd0,  8'hD5, 8'd3, 8'h20, 1'b0, 7'd2},
    {8'd25, 8'hD5, 8'd4, 8'h55, 1'b0, 7'd1},
    {8'd3,  8'hD4, 8'd4, 8'h30, 1'b0, 7'd2},
    {8'd2,  8'hD5, 8'd6, 8'hC0, 1'b1, 7'd4},
    {8'd1,  8'h00, 8'd2, 8'hD5, 1'b0, 7'd1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic e);
    @(negedge clk);
    rxValid = 1'b1;
    rxData  = b;
    rxErr   = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b0;
      rxErr   = 1'b0;
      rxData  = 8'h00;
    end
  endtask

  task automatic sendFrame(input int preLen, input logic [7:0] sfd, input int payLen,
                           input logic [7:0] seed, input int errIdx);
    for (int i = 0; i < preLen; i++) sendByte(8'h55, 1'b0);
    sendByte(sfd, 1'b0);
    for (int i = 0; i < payLen; i++) sendByte(seed + 8'(i), i == errIdx);
  endtask

  task automatic clearCap();
    capN = 0; discSeen = 0; capSof = '0; capEof = '0; capErr = '0;
  endtask

  task automatic verifyFrame(input string tag, input int base, input int expN,
                             input logic [7:0] seed, input bit expErr);
    for (int i = 0; i < expN; i++) begin
      check(capData[base+i] == seed + 8'(i), {tag, " R3 data"}, capData[base+i], seed + 8'(i));
      check(capSof[base+i] == (i == 0), {tag, " R6 sof"}, capSof[base+i], i == 0);
      check(capEof[base+i] == (i == expN-1), {tag, " R6 eof"}, capEof[base+i], i == expN-1);
      check(capErr[base+i] == (expErr && i == expN-1), {tag, " R8 err"}, capErr[base+i],
            expErr && i == expN-1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] cnt0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!outValid && !outSof && !outEof && !outErr && !discardFlag, "R1 reset outputs",
          {outValid, outSof, outEof, outErr, discardFlag}, 0);
    check(discardCount == 0, "R1 reset count", discardCount, 0);
    rstN = 1'b1;
    idle(2);
    check(!outValid && !discardFlag && discardCount == 0, "R1 after release",
          {outValid, discardFlag}, 0);

    // table of frames: R2 R3 R4 R6 R8
    for (int v = 0; v < 6; v++) begin
      int preLen, payLen, gap;
      logic [7:0] sfd, seed;
      bit e, good;
      preLen = int'(VECS[v][39:32]);
      sfd    = VECS[v][31:24];
      payLen = int'(VECS[v][23:16]);
      seed   = VECS[v][15:8];
      e      = VECS[v][7];
      gap    = int'(VECS[v][6:0]);
      good   = (sfd == 8'hD5);
      clearCap();
      cnt0 = discardCount;
      sendFrame(preLen, sfd, payLen, seed, e ? 1 : -1);
      idle(gap + 2);
      check(capN == (good ? payLen : 0), $sformatf("R2 R4 vec%0d count", v), capN,
            good ? payLen : 0);
      check(discSeen == (good ? 0 : 1), $sformatf("R4 vec%0d flag", v), discSeen, !good);
      check(discardCount == cnt0 + (good ? 16'd0 : 16'd1), $sformatf("R4 vec%0d cnt", v),
            discardCount, cnt0 + (good ? 16'd0 : 16'd1));
      if (good) verifyFrame($sformatf("vec%0d", v), 0, payLen, seed, e);
    end

    // R5: valid falls during preamble
    clearCap(); cnt0 = discardCount;
    for (int i = 0; i < 4; i++) sendByte(8'h55, 1'b0);
    idle(3);
    check(capN == 0, "R5 no output", capN, 0);
    check(discSeen == 1 && discardCount == cnt0 + 16'd1, "R5 discard", discardCount, cnt0 + 16'd1);

    // R4: bad delimiter followed by 55, D5 and data stays ignored
    clearCap(); cnt0 = discardCount;
    sendByte(8'h55, 1'b0); sendByte(8'h13, 1'b0);
    sendByte(8'h55, 1'b0); sendByte(8'hD5, 1'b0);
    sendByte(8'hAA, 1'b0); sendByte(8'hBB, 1'b0);
    idle(3);
    check(capN == 0, "R4 ignored tail", capN, 0);
    check(discSeen == 1 && discardCount == cnt0 + 16'd1, "R4 single discard", discSeen, 1);

    // R7: delimiter with no payload
    clearCap(); cnt0 = discardCount;
    sendByte(8'h55, 1'b0); sendByte(8'hD5, 1'b0);
    idle(3);
    check(capN == 0, "R7 no output", capN, 0);
    check(discSeen == 0 && discardCount == cnt0, "R7 no discard", discSeen, 0);

    // R6: single-byte payload and last-byte timing
    clearCap();
    sendFrame(3, 8'hD5, 0, 8'h00, -1);
    sendByte(8'h77, 1'b0);
    @(negedge clk);
    rxValid = 1'b0;
    check(!outValid, "R6 held back", outValid, 0);
    @(negedge clk);
    check(outValid && outData == 8'h77 && outSof && outEof, "R6 single byte timing",
          {outValid, outSof, outEof, outData}, {3'b111, 8'h77});
    idle(2);

    // R9: two frames with a single idle cycle between them
    clearCap();
    sendFrame(2, 8'hD5, 3, 8'h60, -1);
    idle(1);
    sendFrame(2, 8'hD5, 3, 8'h40, -1);
    idle(3);
    check(capN == 6, "R9 both frames", capN, 6);
    verifyFrame("R9 first", 0, 3, 8'h60, 1'b0);
    verifyFrame("R9 second", 3, 3, 8'h40, 1'b0);

    // R8: error during preamble and on delimiter does not block acceptance
    clearCap();
    sendByte(8'h55, 1'b1); sendByte(8'hD5, 1'b1);
    sendByte(8'h01, 1'b0); sendByte(8'h02, 1'b0);
    idle(3);
    check(capN == 2, "R8 accepted despite error", capN, 2);
    verifyFrame("R8 preamble err", 0, 2, 8'h01, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule